// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a processor core that retires one instruction on every clock edge. It supports a sixteen-instruction subset of a 32-bit load/store instruction set with three instruction formats. The supported instructions are register-register arithmetic and logic, immediate arithmetic and logic, word load and store, two conditional branches, and an absolute jump. Instruction memory and data memory are word arrays inside the core. The instruction memory is read-only and is filled by the environment before reset is released. Data memory is filled the same way and is then updated by stores.

Decoding happens in two stages. The opcode selects the datapath controls and an operation class. For register-register instructions, that class defers to the low four bits of the function field, and those four bits are themselves the ALU code.

The core reports what each instruction retires on its output ports: the program counter, the register writeback, and the data-memory store. An environment can follow execution instruction by instruction through these ports.

Top module: `scpu_core`

## Requirements
- R1: While `rst` is high, `pc_o` reads 0 and `wb_en` and `st_en` are 0. Reset clears every register to 0.
- R2: Opcode values: 0x00 register-register, 0x02 jump, 0x04 branch-if-equal, 0x05 branch-if-not-equal, 0x08 add-immediate, 0x0a set-less-than-immediate, 0x0c and-immediate, 0x0d or-immediate, 0x0e xor-immediate, 0x23 load word, 0x2b store word. Any other opcode writes nothing and advances the PC by 4.
- R3: For opcode 0, the function field in bits [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x2a set-less-than. The ALU code is the low four bits of that field. The result goes to the register named by bits [15:11]. The sources are named by bits [25:21] (first) and [20:16] (second).
- R4: Set-less-than and its immediate form produce 1 when the first operand is smaller as a signed 32-bit number, and 0 otherwise.
- R5: Immediate arithmetic and logic instructions write to the register named by bits [20:16]. The 16-bit immediate is sign-extended for add-immediate and set-less-than-immediate. It is zero-extended for the and, or and xor immediate forms.
- R6: A load writes to register [20:16] the data-memory word at address rs + sign-extended immediate. The word index is the address above its two low bits, taken modulo the memory depth.
- R7: A store writes register [20:16] to data memory at the same kind of address, on the clock edge that ends the instruction. It raises `st_en` with `st_addr`/`st_data` and performs no register write.
- R8: A branch adds 4 plus four times the sign-extended immediate to the PC when its condition holds: equal for 0x04, not equal for 0x05. Otherwise it adds 4. Branches write nothing.
- R9: A jump sets the PC to bits [31:28] of PC+4, followed by the 26-bit target field, followed by two zero bits. A jump writes nothing.
- R10: Register 0 reads as 0 even after an instruction names it as destination.
- R11: Each instruction that is not a branch or jump advances the PC by exactly 4 in one cycle.
- R12: A register written by one instruction holds the new value for the very next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| wb_en | output | 1 | The instruction writes a register at the coming edge |
| wb_reg | output | 5 | Destination register number |
| wb_data | output | 32 | Value being written |
| st_en | output | 1 | The instruction stores to data memory at the coming edge |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Word being stored |

## Verification
The bench aims at the places where a single-cycle core goes wrong in subtle ways. One is extension of a 0x8001 or 0xFFF0 immediate: a core that sign-extends the logic forms writes ones into the upper half. Another is a signed compare of a negative operand, where an unsigned compare yields 0 instead of 1. A write to register 0 must not make that register read back nonzero. A load must see a store made earlier in the same program. The bench runs branches both taken and not taken, and jumps, including one that jumps to itself; a wrong offset scale or a wrong upper-bit source sends the PC somewhere else. Seeded random programs then compare every cycle's PC, writeback and store against an instruction-level model kept in the bench, so a mis-decoded opcode or wrong destination field shows up on the first instruction that uses it.

// File: rtl/scpu_pkg.sv
`timescale 1ns/1ps
package scpu_pkg;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;
    localparam int NREGS  = 1 << RIDX_W;
    localparam int IMM_W  = 16;
    localparam int TGT_W  = 26;

    localparam logic [5:0] OP_REG  = 6'h00;
    localparam logic [5:0] OP_JMP  = 6'h02;
    localparam logic [5:0] OP_BEQ  = 6'h04;
    localparam logic [5:0] OP_BNE  = 6'h05;
    localparam logic [5:0] OP_ADDI = 6'h08;
    localparam logic [5:0] OP_SLTI = 6'h0a;
    localparam logic [5:0] OP_ANDI = 6'h0c;
    localparam logic [5:0] OP_ORI  = 6'h0d;
    localparam logic [5:0] OP_XORI = 6'h0e;
    localparam logic [5:0] OP_LW   = 6'h23;
    localparam logic [5:0] OP_SW   = 6'h2b;

    // ALU code equals low four bits of the function field
    typedef enum logic [3:0] {
        FN_ADD = 4'b0000,
        FN_SUB = 4'b0010,
        FN_AND = 4'b0100,
        FN_OR  = 4'b0101,
        FN_XOR = 4'b0110,
        FN_SLT = 4'b1010
    } alu_fn_e;

    typedef enum logic [2:0] {
        CLS_FUNCT, CLS_ADD, CLS_SUB, CLS_AND, CLS_OR, CLS_XOR, CLS_SLT
    } alu_class_e;

    typedef struct packed {
        logic       reg_write;
        logic       dst_rd;
        logic       sign_ext;
        logic       src_imm;
        logic       mem_write;
        logic       mem_to_reg;
        logic       br_eq;
        logic       br_ne;
        logic       jump;
        alu_class_e alu_class;
    } ctrl_t;

    function automatic logic [XLEN-1:0] extend_imm(input logic [IMM_W-1:0] imm, input logic sgn);
        return {{(XLEN-IMM_W){sgn & imm[IMM_W-1]}}, imm};
    endfunction
endpackage

// File: rtl/scpu_decode.sv
`timescale 1ns/1ps
module scpu_decode
    import scpu_pkg::*;
(
    input  logic [5:0] op,
    input  logic [3:0] funct_lo,
    output ctrl_t      ctrl,
    output alu_fn_e    fn
);
    // level one: opcode to datapath controls and operation class
    always_comb begin
        ctrl = '0;
        ctrl.alu_class = CLS_ADD;
        case (op)
            OP_REG:  begin ctrl.reg_write = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_class = CLS_FUNCT; end
            OP_ADDI: begin ctrl.reg_write = 1'b1; ctrl.sign_ext = 1'b1; ctrl.src_imm = 1'b1; ctrl.alu_class = CLS_ADD; end
            OP_SLTI: begin ctrl.reg_write = 1'b1; ctrl.sign_ext = 1'b1; ctrl.src_imm = 1'b1; ctrl.alu_class = CLS_SLT; end
            OP_ANDI: begin ctrl.reg_write = 1'b1; ctrl.src_imm = 1'b1; ctrl.alu_class = CLS_AND; end
            OP_ORI:  begin ctrl.reg_write = 1'b1; ctrl.src_imm = 1'b1; ctrl.alu_class = CLS_OR; end
            OP_XORI: begin ctrl.reg_write = 1'b1; ctrl.src_imm = 1'b1; ctrl.alu_class = CLS_XOR; end
            OP_LW:   begin ctrl.reg_write = 1'b1; ctrl.sign_ext = 1'b1; ctrl.src_imm = 1'b1; ctrl.mem_to_reg = 1'b1; end
            OP_SW:   begin ctrl.sign_ext = 1'b1; ctrl.src_imm = 1'b1; ctrl.mem_write = 1'b1; end
            OP_BEQ:  begin ctrl.br_eq = 1'b1; ctrl.alu_class = CLS_SUB; end
            OP_BNE:  begin ctrl.br_ne = 1'b1; ctrl.alu_class = CLS_SUB; end
            OP_JMP:  ctrl.jump = 1'b1;
            default: ;
        endcase
    end

    // level two: class (and function field) to ALU code
    always_comb begin
        case (ctrl.alu_class)
            CLS_FUNCT: fn = alu_fn_e'(funct_lo);
            CLS_SUB:   fn = FN_SUB;
            CLS_AND:   fn = FN_AND;
            CLS_OR:    fn = FN_OR;
            CLS_XOR:   fn = FN_XOR;
            CLS_SLT:   fn = FN_SLT;
            default:   fn = FN_ADD;
        endcase
    end
endmodule

// File: rtl/scpu_regfile.sv
`timescale 1ns/1ps
module scpu_regfile
    import scpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [RIDX_W-1:0] raddr_a,
    input  logic [RIDX_W-1:0] raddr_b,
    output logic [XLEN-1:0]   rdata_a,
    output logic [XLEN-1:0]   rdata_b
);
    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

    // R12: a write is seen by the following read of the same register
    a_r12_write_visible: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> (raddr_a != $past(waddr) || rdata_a == $past(wdata)))
        else $error("a_r12_write_visible");

    // R10: writing register 0 leaves it reading zero
    a_r10_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == '0) |=> (raddr_b != '0 || rdata_b == '0))
        else $error("a_r10_zero_reg");
endmodule

// File: rtl/scpu_alu.sv
`timescale 1ns/1ps
module scpu_alu
    import scpu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (fn)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/scpu_nextpc.sv
`timescale 1ns/1ps
module scpu_nextpc
    import scpu_pkg::*;
(
    input  logic [XLEN-1:0]  pc,
    input  logic [IMM_W-1:0] off,
    input  logic [TGT_W-1:0] target,
    input  logic             br_eq,
    input  logic             br_ne,
    input  logic             jump,
    input  logic             zero,
    output logic [XLEN-1:0]  next_pc
);
    localparam int HI_W = XLEN - TGT_W - 2;

    logic [XLEN-1:0] pc_inc, br_tgt, jmp_tgt;
    logic            take;

    assign pc_inc  = pc + XLEN'(4);
    assign br_tgt  = pc_inc + {{(XLEN-IMM_W-2){off[IMM_W-1]}}, off, 2'b00};
    assign jmp_tgt = {pc_inc[XLEN-1 -: HI_W], target, 2'b00};
    assign take    = (br_eq & zero) | (br_ne & ~zero);

    always_comb begin
        if (jump)      next_pc = jmp_tgt;
        else if (take) next_pc = br_tgt;
        else           next_pc = pc_inc;
    end
endmodule

// File: rtl/scpu_core.sv
`timescale 1ns/1ps
module scpu_core
    import scpu_pkg::*;
#(
    parameter int IMEM_WORDS = 256,
    parameter int DMEM_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst,
    output logic [XLEN-1:0]   pc_o,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_reg,
    output logic [XLEN-1:0]   wb_data,
    output logic              st_en,
    output logic [XLEN-1:0]   st_addr,
    output logic [XLEN-1:0]   st_data
);
    localparam int IMEM_AW = $clog2(IMEM_WORDS);
    localparam int DMEM_AW = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
    end

    logic [XLEN-1:0]   pc_q, next_pc, instr;
    logic [5:0]        op;
    logic [RIDX_W-1:0] rs, rt, rd;
    logic [IMM_W-1:0]  imm16;
    ctrl_t             ctrl;
    alu_fn_e           fn;
    logic [XLEN-1:0]   rs_val, rt_val, ext_imm, opnd_b, alu_y, mem_rd;
    logic              zero;

    assign instr = imem[pc_q[IMEM_AW+1:2]];
    assign op    = instr[31:26];
    assign rs    = instr[25:21];
    assign rt    = instr[20:16];
    assign rd    = instr[15:11];
    assign imm16 = instr[IMM_W-1:0];

    scpu_decode u_dec (
        .op       (op),
        .funct_lo (instr[3:0]),
        .ctrl     (ctrl),
        .fn       (fn)
    );

    scpu_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (wb_en),
        .waddr   (wb_reg),
        .wdata   (wb_data),
        .raddr_a (rs),
        .raddr_b (rt),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    assign ext_imm = extend_imm(imm16, ctrl.sign_ext);
    assign opnd_b  = ctrl.src_imm ? ext_imm : rt_val;

    scpu_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (opnd_b),
        .fn   (fn),
        .y    (alu_y),
        .zero (zero)
    );

    assign mem_rd  = dmem[alu_y[DMEM_AW+1:2]];
    assign wb_en   = ctrl.reg_write & ~rst;
    assign wb_reg  = ctrl.dst_rd ? rd : rt;
    assign wb_data = ctrl.mem_to_reg ? mem_rd : alu_y;
    assign st_en   = ctrl.mem_write & ~rst;
    assign st_addr = alu_y;
    assign st_data = rt_val;

    always_ff @(posedge clk) begin
        if (st_en) dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
    end

    scpu_nextpc u_npc (
        .pc      (pc_q),
        .off     (imm16),
        .target  (instr[TGT_W-1:0]),
        .br_eq   (ctrl.br_eq),
        .br_ne   (ctrl.br_ne),
        .jump    (ctrl.jump),
        .zero    (zero),
        .next_pc (next_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= next_pc;
    end
    assign pc_o = pc_q;

    // R1: first cycle out of reset starts at address zero
    a_r1_reset_pc: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc_q == '0) else $error("a_r1_reset_pc");

    // R11: straight-line instructions advance by one word
    a_r11_seq_pc: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctrl.jump | ctrl.br_eq | ctrl.br_ne))
        |-> pc_q == $past(pc_q) + XLEN'(4)) else $error("a_r11_seq_pc");

    // R8: taken equal-branch lands on the scaled offset
    a_r8_beq_target: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op == OP_BEQ) && $past(rs_val == rt_val))
        |-> pc_q == $past(pc_q) + XLEN'(4) + {{(XLEN-IMM_W-2){$past(imm16[IMM_W-1])}}, $past(imm16), 2'b00})
        else $error("a_r8_beq_target");

    // R5: logic immediates are zero-extended, arithmetic ones sign-extended
    a_r5_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ANDI || op == OP_ORI || op == OP_XORI) |-> opnd_b[XLEN-1:IMM_W] == '0)
        else $error("a_r5_zero_ext");
    a_r5_sign_ext: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADDI || op == OP_SLTI || op == OP_LW || op == OP_SW)
        |-> opnd_b[XLEN-1:IMM_W] == {(XLEN-IMM_W){instr[IMM_W-1]}})
        else $error("a_r5_sign_ext");

    // R6: a load writes back the addressed memory word
    a_r6_load_wb: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LW) |-> (wb_en && wb_data == mem_rd)) else $error("a_r6_load_wb");

    // R7: a store never writes a register
    a_r7_store_no_wb: assert property (@(posedge clk) disable iff (rst)
        st_en |-> !wb_en) else $error("a_r7_store_no_wb");

    // R9: a jump writes nothing
    a_r9_jump_quiet: assert property (@(posedge clk) disable iff (rst)
        (op == OP_JMP) |-> (!wb_en && !st_en)) else $error("a_r9_jump_quiet");
endmodule

// File: tb/tb_scpu_core.sv
`timescale 1ns/1ps
module tb_scpu_core;
    localparam int IW = 256;
    localparam int DW = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o, wb_data, st_addr, st_data;
    logic        wb_en, st_en;
    logic [4:0]  wb_reg;

    scpu_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut (
        .clk(clk), .rst(rst), .pc_o(pc_o), .wb_en(wb_en), .wb_reg(wb_reg),
        .wb_data(wb_data), .st_en(st_en), .st_addr(st_addr), .st_data(st_data)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;

    logic [31:0] prog [IW];
    logic [31:0] dm   [DW];
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [DW];
    logic [31:0] m_pc;

    logic [31:0] tr_pc [64];
    logic [31:0] tr_wd [64];
    logic [31:0] tr_sa [64];
    logic [31:0] tr_sd [64];
    logic        tr_we [64];
    logic        tr_se [64];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] f, input logic [4:0] d, input logic [4:0] s, input logic [4:0] t);
        return {6'h00, s, t, d, 5'h00, f};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] t, input logic [4:0] s, input logic [15:0] imm);
        return {op, s, t, imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [25:0] tgt);
        return {6'h02, tgt};
    endfunction

    // instruction-level model of one retirement, from the requirements
    task automatic model_step(output logic e_we, output logic [4:0] e_rg, output logic [31:0] e_wd,
                              output logic e_se, output logic [31:0] e_sa, output logic [31:0] e_sd,
                              output logic [31:0] e_np, output string tag);
        logic [31:0] w, a, b, se, ze, addr;
        w  = prog[m_pc[9:2]];
        a  = m_reg[w[25:21]];
        b  = m_reg[w[20:16]];
        se = {{16{w[15]}}, w[15:0]};
        ze = {16'h0, w[15:0]};
        e_we = 0; e_rg = w[20:16]; e_wd = 0; e_se = 0; e_sa = 0; e_sd = 0;
        e_np = m_pc + 4; tag = "R2";
        addr = a + se;
        case (w[31:26])
            6'h00: begin
                tag = "R3"; e_we = 1; e_rg = w[15:11];
                case (w[5:0])
                    6'h20: e_wd = a + b;
                    6'h22: e_wd = a - b;
                    6'h24: e_wd = a & b;
                    6'h25: e_wd = a | b;
                    6'h26: e_wd = a ^ b;
                    6'h2a: begin e_wd = {31'h0, $signed(a) < $signed(b)}; tag = "R4"; end
                    default: e_wd = 0;
                endcase
            end
            6'h08: begin tag = "R5"; e_we = 1; e_wd = a + se; end
            6'h0a: begin tag = "R4"; e_we = 1; e_wd = {31'h0, $signed(a) < $signed(se)}; end
            6'h0c: begin tag = "R5"; e_we = 1; e_wd = a & ze; end
            6'h0d: begin tag = "R5"; e_we = 1; e_wd = a | ze; end
            6'h0e: begin tag = "R5"; e_we = 1; e_wd = a ^ ze; end
            6'h23: begin tag = "R6"; e_we = 1; e_wd = m_mem[addr[9:2]]; end
            6'h2b: begin tag = "R7"; e_se = 1; e_sa = addr; e_sd = b; end
            6'h04: begin tag = "R8"; if (a == b) e_np = m_pc + 4 + (se << 2); end
            6'h05: begin tag = "R8"; if (a != b) e_np = m_pc + 4 + (se << 2); end
            6'h02: begin tag = "R9"; e_np = {e_np[31:28], w[25:0], 2'b00}; end
            default: ;
        endcase
    endtask

    task automatic run_prog(input int ncyc, input bit rec);
        logic        e_we, e_se;
        logic [4:0]  e_rg;
        logic [31:0] e_wd, e_sa, e_sd, e_np;
        string       tag;
        rst = 1'b1;
        #1;
        for (int i = 0; i < IW; i++) dut.imem[i] = prog[i];
        for (int i = 0; i < DW; i++) begin dut.dmem[i] = dm[i]; m_mem[i] = dm[i]; end
        for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
        m_pc = 32'h0;
        @(negedge clk); @(negedge clk);
        #1;
        chk(pc_o == 32'h0, "R1", "pc in reset", pc_o, 32'h0);
        chk(wb_en == 1'b0, "R1", "wb_en in reset", {31'h0, wb_en}, 32'h0);
        chk(st_en == 1'b0, "R1", "st_en in reset", {31'h0, st_en}, 32'h0);
        rst = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            #1;
            model_step(e_we, e_rg, e_wd, e_se, e_sa, e_sd, e_np, tag);
            chk(pc_o == m_pc, "R11", "pc", pc_o, m_pc);
            chk(wb_en == e_we, tag, "wb_en", {31'h0, wb_en}, {31'h0, e_we});
            if (e_we) begin
                chk(wb_reg == e_rg, tag, "wb_reg", {27'h0, wb_reg}, {27'h0, e_rg});
                chk(wb_data == e_wd, tag, "wb_data", wb_data, e_wd);
            end
            chk(st_en == e_se, "R7", "st_en", {31'h0, st_en}, {31'h0, e_se});
            if (e_se) begin
                chk(st_addr == e_sa, "R7", "st_addr", st_addr, e_sa);
                chk(st_data == e_sd, "R7", "st_data", st_data, e_sd);
            end
            if (rec && k < 64) begin
                tr_pc[k] = pc_o; tr_wd[k] = wb_data; tr_we[k] = wb_en;
                tr_se[k] = st_en; tr_sa[k] = st_addr; tr_sd[k] = st_data;
            end
            if (e_we && e_rg != 5'd0) m_reg[e_rg] = e_wd;
            if (e_se) m_mem[e_sa[9:2]] = e_sd;
            m_pc = e_np;
            @(negedge clk);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < IW; i++) prog[i] = 32'hfc00_0000; // unknown opcode 0x3f
        for (int i = 0; i < DW; i++) dm[i] = 32'h1000_0000 + 32'(i);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));

        // directed program: every instruction, branch both ways, jumps
        clear_prog();
        prog[0]  = enc_i(6'h08, 5'd1, 5'd0, 16'd5);
        prog[1]  = enc_i(6'h08, 5'd2, 5'd0, 16'hfffd);
        prog[2]  = enc_i(6'h0d, 5'd3, 5'd0, 16'h8001);
        prog[3]  = enc_r(6'h20, 5'd4, 5'd1, 5'd2);
        prog[4]  = enc_r(6'h22, 5'd5, 5'd1, 5'd2);
        prog[5]  = enc_r(6'h24, 5'd6, 5'd2, 5'd3);
        prog[6]  = enc_r(6'h25, 5'd7, 5'd1, 5'd3);
        prog[7]  = enc_r(6'h26, 5'd8, 5'd2, 5'd1);
        prog[8]  = enc_r(6'h2a, 5'd9, 5'd2, 5'd1);
        prog[9]  = enc_i(6'h0a, 5'd10, 5'd1, 16'hffff);
        prog[10] = enc_i(6'h0c, 5'd11, 5'd2, 16'hfff0);
        prog[11] = enc_i(6'h0e, 5'd12, 5'd1, 16'hffff);
        prog[12] = enc_i(6'h2b, 5'd7, 5'd1, 16'd3);
        prog[13] = enc_i(6'h23, 5'd13, 5'd0, 16'd8);
        prog[14] = enc_r(6'h20, 5'd0, 5'd1, 5'd1);
        prog[15] = enc_r(6'h20, 5'd14, 5'd0, 5'd1);
        prog[16] = enc_i(6'h04, 5'd2, 5'd1, 16'd5);
        prog[17] = enc_i(6'h05, 5'd2, 5'd1, 16'd2);
        prog[18] = enc_i(6'h08, 5'd15, 5'd0, 16'd1);
        prog[19] = enc_i(6'h08, 5'd15, 5'd0, 16'd2);
        prog[20] = enc_i(6'h04, 5'd4, 5'd4, 16'd1);
        prog[21] = enc_i(6'h08, 5'd15, 5'd0, 16'd3);
        prog[22] = enc_j(26'd25);
        prog[25] = enc_r(6'h20, 5'd16, 5'd13, 5'd14);
        prog[26] = 32'hfc21_0000;
        prog[27] = enc_j(26'd27);
        run_prog(30, 1'b1);

        chk(tr_wd[1] == 32'hffff_fffd, "R5", "addi sign-extended", tr_wd[1], 32'hffff_fffd);
        chk(tr_wd[2] == 32'h0000_8001, "R5", "ori zero-extended", tr_wd[2], 32'h0000_8001);
        chk(tr_wd[3] == 32'd2, "R12", "add uses fresh r1/r2", tr_wd[3], 32'd2);
        chk(tr_wd[4] == 32'd8, "R3", "sub", tr_wd[4], 32'd8);
        chk(tr_wd[7] == 32'hffff_fff8, "R3", "xor", tr_wd[7], 32'hffff_fff8);
        chk(tr_wd[8] == 32'd1, "R4", "slt negative < positive", tr_wd[8], 32'd1);
        chk(tr_wd[9] == 32'd0, "R4", "slti 5 < -1", tr_wd[9], 32'd0);
        chk(tr_wd[10] == 32'h0000_fff0, "R5", "andi zero-extended", tr_wd[10], 32'h0000_fff0);
        chk(tr_se[12] && tr_sa[12] == 32'd8, "R7", "sw address", tr_sa[12], 32'd8);
        chk(tr_sd[12] == 32'h0000_8005 && !tr_we[12], "R7", "sw data no wb", tr_sd[12], 32'h0000_8005);
        chk(tr_wd[13] == 32'h0000_8005, "R6", "lw sees earlier sw", tr_wd[13], 32'h0000_8005);
        chk(tr_wd[15] == 32'd5, "R10", "r0 stays zero after write", tr_wd[15], 32'd5);
        chk(tr_pc[17] == 32'd68, "R8", "beq not taken", tr_pc[17], 32'd68);
        chk(tr_pc[18] == 32'd80, "R8", "bne taken", tr_pc[18], 32'd80);
        chk(tr_pc[19] == 32'd88, "R8", "beq taken", tr_pc[19], 32'd88);
        chk(tr_pc[20] == 32'd100, "R9", "jump target", tr_pc[20], 32'd100);
        chk(tr_wd[20] == 32'h0000_800a, "R12", "chain through lw", tr_wd[20], 32'h0000_800a);
        chk(!tr_we[21] && !tr_se[21], "R2", "unknown opcode quiet", {31'h0, tr_we[21]}, 32'h0);
        chk(tr_pc[22] == 32'd108, "R2", "unknown opcode pc+4", tr_pc[22], 32'd108);
        chk(tr_pc[23] == 32'd108, "R9", "jump to self", tr_pc[23], 32'd108);

        // reset clears registers: read regs left nonzero by the previous run
        clear_prog();
        prog[0] = enc_r(6'h25, 5'd1, 5'd5, 5'd13);
        prog[1] = enc_j(26'd1);
        run_prog(3, 1'b1);
        chk(tr_wd[0] == 32'h0, "R1", "registers cleared by reset", tr_wd[0], 32'h0);

        // seeded random programs
        for (int p = 0; p < 30; p++) begin
            for (int i = 0; i < DW; i++) dm[i] = $urandom;
            for (int i = 0; i < IW; i++) begin
                logic [4:0]  s, t, d;
                logic [15:0] imm;
                logic [5:0]  fsel [6];
                fsel[0] = 6'h20; fsel[1] = 6'h22; fsel[2] = 6'h24;
                fsel[3] = 6'h25; fsel[4] = 6'h26; fsel[5] = 6'h2a;
                s = 5'($urandom_range(0, 7));
                t = 5'($urandom_range(0, 7));
                d = 5'($urandom_range(0, 7));
                imm = 16'($urandom);
                case ($urandom_range(0, 15))
                    0, 1, 2, 3: prog[i] = enc_r(fsel[$urandom_range(0, 5)], d, s, t);
                    4:  prog[i] = enc_i(6'h08, t, s, imm);
                    5:  prog[i] = enc_i(6'h0a, t, s, imm);
                    6:  prog[i] = enc_i(6'h0c, t, s, imm);
                    7:  prog[i] = enc_i(6'h0d, t, s, imm);
                    8:  prog[i] = enc_i(6'h0e, t, s, imm);
                    9, 10: prog[i] = enc_i(6'h23, t, s, imm);
                    11, 12: prog[i] = enc_i(6'h2b, t, s, imm);
                    13: prog[i] = enc_i(6'h04, t, s, 16'($signed($urandom_range(0, 16)) - 8));
                    14: prog[i] = enc_i(6'h05, t, s, 16'($signed($urandom_range(0, 16)) - 8));
                    default: prog[i] = enc_j(26'($urandom_range(0, IW - 1)));
                endcase
            end
            run_prog(200, 1'b0);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule